// File: doc/BRIEF.md
# Remote Flag-Bit Write-Through Controller

This block sits on a supervisor register bus and turns a word write into an update of one bit in a remote flag array. Two selector registers are each paired with a data port. Software first loads a selector with a bank number, a bit index and a valid flag. A later write to the paired data port then becomes a single request toward the remote unit. The request carries the bank, the index and bit 0 of the written word.

After a request is launched, a read-only busy bit stays set until the remote side reports that it has finished. While busy is set, the block ignores every write to the selectors and to the data ports. An update in flight therefore cannot be redirected or duplicated. Software polls the busy bit before it reprograms a selector or issues the next data write.

Top module: `flagwt_ctrl`

## Requirements
- R1: After reset both selectors read as zero (valid flag cleared), the busy bit reads 0 and `rq_valid` is low.
- R2: In address space 0x6F, selector 0 sits at offset 0x80 and selector 1 at offset 0x88. A write stores bit 63 as the valid flag, bit 6 as the bank and bits 5:0 as the bit index. A read returns those three fields in the same positions, with every other bit zero.
- R3: A write to data port 0 (offset 0x00) or data port 1 (offset 0x08) in space 0x6F, while its selector is valid and busy is 0, raises `rq_valid` in the next cycle. `rq_bank` and `rq_index` come from that port's selector, and `rq_value` equals bit 0 of the written word.
- R4: A data-port write whose selector has the valid flag at 0 is discarded. No request is raised and busy stays 0.
- R5: While `rq_valid` is high and `rq_ready` is low, `rq_valid`, `rq_bank`, `rq_index` and `rq_value` hold steady. `rq_valid` drops in the cycle after a clock edge at which `rq_ready` was high.
- R6: Busy is set in the cycle after an accepted data-port write. It stays set until a one-cycle `rq_done` pulse arrives after the request has been taken, and it reads 0 in the following cycle. An `rq_done` that arrives while the request is still pending is ignored.
- R7: While busy is 1, writes to either selector leave its contents unchanged. Writes to either data port launch no new request and do not alter the pending one.
- R8: The busy status register sits at offset 0xC0 in space 0x6F. It shows busy in bit 0, reads zero in bits 63:1, and ignores writes.
- R9: Reads from any other offset in space 0x6F, reads from the data-port offsets, and every access in any other space return zero. Writes there change no selector and launch no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (read data is combinational) |
| cpu_space | input | 8 | Address-space code |
| cpu_off | input | 8 | Offset within the address space |
| cpu_wdata | input | 64 | Write data |
| cpu_rdata | output | 64 | Read data, zero when no mapped register is read |
| rq_valid | output | 1 | Remote update request pending |
| rq_ready | input | 1 | Remote side takes the request at this edge |
| rq_bank | output | 1 | Target bank of the request |
| rq_index | output | 6 | Target bit index within the bank |
| rq_value | output | 1 | New value of the target bit |
| rq_done | input | 1 | One-cycle pulse: the remote update has completed |

## Verification
The bench sweeps every bit index in both banks through both ports, with a varied remote ready delay. A design that swapped ports or banks, or that forwarded a wider slice of the data word, would put a wrong value on the request fields. While busy, it aims writes at both selectors and both data ports. A design that let them through would show a changed selector on readback or a second request after completion. It also sends completion pulses early, before the request is taken, where a design that cleared busy too soon would read idle while the update is still in flight. Invalid selectors, unmapped offsets, a foreign address space and the read-only busy register are probed, to catch stray requests and non-zero read data.

// File: rtl/flagwt_pkg.sv
package flagwt_pkg;

   typedef enum logic [1:0] {
      HIT_NONE  = 2'd0,
      HIT_SEL   = 2'd1,
      HIT_DPORT = 2'd2,
      HIT_BUSY  = 2'd3
   } fw_hit_e;

endpackage

// File: rtl/flagwt_decode.sv
module flagwt_decode
   import flagwt_pkg::*;
#(
   parameter int SPACE_W     = 8,
   parameter int OFF_W       = 8,
   parameter int NUM_PORTS   = 2,
   parameter int PORT_W      = 1,
   parameter int SPACE_CODE  = 'h6F,
   parameter int SEL_BASE    = 'h80,
   parameter int DPORT_BASE  = 'h00,
   parameter int PORT_STRIDE = 8,
   parameter int BUSY_OFF    = 'hC0
) (
   input  logic [SPACE_W-1:0] space_i,
   input  logic [OFF_W-1:0]   off_i,
   output fw_hit_e            hit_o,
   output logic [PORT_W-1:0]  port_o
);

   localparam logic [SPACE_W-1:0] SPACE_V = SPACE_W'(SPACE_CODE);
   localparam logic [OFF_W-1:0]   BUSY_V  = OFF_W'(BUSY_OFF);

   logic [NUM_PORTS-1:0] sel_m;
   logic [NUM_PORTS-1:0] dp_m;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_match
      assign sel_m[p] = (off_i == OFF_W'(SEL_BASE + p * PORT_STRIDE));
      assign dp_m[p]  = (off_i == OFF_W'(DPORT_BASE + p * PORT_STRIDE));
   end

   always_comb begin
      hit_o  = HIT_NONE;
      port_o = '0;
      if (space_i == SPACE_V) begin
         if (off_i == BUSY_V) begin
            hit_o = HIT_BUSY;
         end
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel_m[p]) begin
               hit_o  = HIT_SEL;
               port_o = PORT_W'(p);
            end
            if (dp_m[p]) begin
               hit_o  = HIT_DPORT;
               port_o = PORT_W'(p);
            end
         end
      end
   end

endmodule

// File: rtl/flagwt_selbank.sv
module flagwt_selbank #(
   parameter int NUM_PORTS = 2,
   parameter int PORT_W    = 1,
   parameter int DATA_W    = 64,
   parameter int BANK_W    = 1,
   parameter int IDX_W     = 6
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en_i,
   input  logic [PORT_W-1:0]                    wr_port_i,
   input  logic [DATA_W-1:0]                    wdata_i,
   input  logic [PORT_W-1:0]                    rd_port_i,
   input  logic                                 busy_i,
   output logic [NUM_PORTS-1:0]                 vld_o,
   output logic [NUM_PORTS-1:0][BANK_W-1:0]     bank_o,
   output logic [NUM_PORTS-1:0][IDX_W-1:0]      idx_o,
   output logic [DATA_W-1:0]                    rd_word_o
);

   localparam int VLD_POS  = DATA_W - 1;
   localparam int BANK_POS = IDX_W;

   logic [NUM_PORTS-1:0]             vld_q;
   logic [NUM_PORTS-1:0][BANK_W-1:0] bank_q;
   logic [NUM_PORTS-1:0][IDX_W-1:0]  idx_q;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
      logic hit;
      assign hit = wr_en_i && (wr_port_i == PORT_W'(p));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[p]  <= 1'b0;
            bank_q[p] <= '0;
            idx_q[p]  <= '0;
         end else if (hit) begin
            vld_q[p]  <= wdata_i[VLD_POS];
            bank_q[p] <= wdata_i[BANK_POS +: BANK_W];
            idx_q[p]  <= wdata_i[IDX_W-1:0];
         end
      end
   end

   always_comb begin
      rd_word_o                     = '0;
      rd_word_o[VLD_POS]            = vld_q[rd_port_i];
      rd_word_o[BANK_POS +: BANK_W] = bank_q[rd_port_i];
      rd_word_o[IDX_W-1:0]          = idx_q[rd_port_i];
   end

   assign vld_o  = vld_q;
   assign bank_o = bank_q;
   assign idx_o  = idx_q;

   // R7: selectors frozen while an update is outstanding
   a_r7_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> ($stable(vld_q) && $stable(bank_q) && $stable(idx_q)));

   // R2: an enabled write captures the valid flag of the word
   a_r2_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (vld_o[$past(wr_port_i)] == $past(wdata_i[VLD_POS])));

endmodule

// File: rtl/flagwt_issue.sv
module flagwt_issue #(
   parameter int NUM_PORTS = 2,
   parameter int PORT_W    = 1,
   parameter int BANK_W    = 1,
   parameter int IDX_W     = 6
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             dp_wr_i,
   input  logic [PORT_W-1:0]                dp_port_i,
   input  logic                             wbit_i,
   input  logic [NUM_PORTS-1:0]             sel_vld_i,
   input  logic [NUM_PORTS-1:0][BANK_W-1:0] sel_bank_i,
   input  logic [NUM_PORTS-1:0][IDX_W-1:0]  sel_idx_i,
   input  logic                             rq_ready_i,
   input  logic                             rq_done_i,
   output logic                             busy_o,
   output logic                             rq_valid_o,
   output logic [BANK_W-1:0]                rq_bank_o,
   output logic [IDX_W-1:0]                 rq_index_o,
   output logic                             rq_value_o
);

   logic busy_q;
   logic rqv_q;
   logic accept;
   logic taken;
   logic finish;

   assign accept = dp_wr_i && !busy_q && sel_vld_i[dp_port_i];
   assign taken  = rqv_q && rq_ready_i;
   assign finish = busy_q && !rqv_q && rq_done_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         rqv_q      <= 1'b0;
         rq_bank_o  <= '0;
         rq_index_o <= '0;
         rq_value_o <= 1'b0;
      end else if (accept) begin
         busy_q     <= 1'b1;
         rqv_q      <= 1'b1;
         rq_bank_o  <= sel_bank_i[dp_port_i];
         rq_index_o <= sel_idx_i[dp_port_i];
         rq_value_o <= wbit_i;
      end else begin
         if (taken) begin
            rqv_q <= 1'b0;
         end
         if (finish) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy_o     = busy_q;
   assign rq_valid_o = rqv_q;

   // R5: request fields hold until taken
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_valid_o && !rq_ready_i) |=> (rq_valid_o && $stable(rq_bank_o)
                                       && $stable(rq_index_o) && $stable(rq_value_o)));

   // R3: a pending request always has busy set
   a_r3_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rq_valid_o |-> busy_o);

   // R6: busy only falls on a completion pulse
   a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !rq_done_i) |=> busy_o);

   // R7: no second request while an update is outstanding
   a_r7_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !rq_valid_o) |=> !rq_valid_o);

endmodule

// File: rtl/flagwt_ctrl.sv
module flagwt_ctrl
   import flagwt_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int SPACE_W     = 8,
   parameter int OFF_W       = 8,
   parameter int NUM_PORTS   = 2,
   parameter int BANK_W      = 1,
   parameter int IDX_W       = 6,
   parameter int SPACE_CODE  = 'h6F,
   parameter int SEL_BASE    = 'h80,
   parameter int DPORT_BASE  = 'h00,
   parameter int PORT_STRIDE = 8,
   parameter int BUSY_OFF    = 'hC0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_wr,
   input  logic               cpu_rd,
   input  logic [SPACE_W-1:0] cpu_space,
   input  logic [OFF_W-1:0]   cpu_off,
   input  logic [DATA_W-1:0]  cpu_wdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic               rq_valid,
   input  logic               rq_ready,
   output logic [BANK_W-1:0]  rq_bank,
   output logic [IDX_W-1:0]   rq_index,
   output logic               rq_value,
   input  logic               rq_done
);

   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
   localparam int SPAN     = NUM_PORTS * PORT_STRIDE;
   localparam int SEL_END  = SEL_BASE + SPAN;
   localparam int DP_END   = DPORT_BASE + SPAN;

   if (NUM_PORTS < 1) begin : g_chk_ports
      $error("flagwt_ctrl: NUM_PORTS must be at least 1");
   end
   if (IDX_W + BANK_W >= DATA_W - 1) begin : g_chk_fields
      $error("flagwt_ctrl: selector fields overlap the valid flag");
   end
   if (SEL_END > (1 << OFF_W) || DP_END > (1 << OFF_W)) begin : g_chk_range
      $error("flagwt_ctrl: register window exceeds offset width");
   end
   if (!(SEL_END <= DPORT_BASE || DP_END <= SEL_BASE)) begin : g_chk_overlap
      $error("flagwt_ctrl: selector and data-port windows overlap");
   end
   if ((BUSY_OFF >= SEL_BASE && BUSY_OFF < SEL_END) ||
       (BUSY_OFF >= DPORT_BASE && BUSY_OFF < DP_END)) begin : g_chk_busy
      $error("flagwt_ctrl: busy offset collides with a port window");
   end

   fw_hit_e                          hit;
   logic [PORT_W-1:0]                port;
   logic                             busy;
   logic [NUM_PORTS-1:0]             sel_vld;
   logic [NUM_PORTS-1:0][BANK_W-1:0] sel_bank;
   logic [NUM_PORTS-1:0][IDX_W-1:0]  sel_idx;
   logic [DATA_W-1:0]                sel_word;
   logic                             sel_wr_en;
   logic                             dp_wr;

   flagwt_decode #(
      .SPACE_W    (SPACE_W),
      .OFF_W      (OFF_W),
      .NUM_PORTS  (NUM_PORTS),
      .PORT_W     (PORT_W),
      .SPACE_CODE (SPACE_CODE),
      .SEL_BASE   (SEL_BASE),
      .DPORT_BASE (DPORT_BASE),
      .PORT_STRIDE(PORT_STRIDE),
      .BUSY_OFF   (BUSY_OFF)
   ) u_decode (
      .space_i(cpu_space),
      .off_i  (cpu_off),
      .hit_o  (hit),
      .port_o (port)
   );

   assign sel_wr_en = cpu_wr && (hit == HIT_SEL) && !busy;
   assign dp_wr     = cpu_wr && (hit == HIT_DPORT);

   flagwt_selbank #(
      .NUM_PORTS(NUM_PORTS),
      .PORT_W   (PORT_W),
      .DATA_W   (DATA_W),
      .BANK_W   (BANK_W),
      .IDX_W    (IDX_W)
   ) u_selbank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (sel_wr_en),
      .wr_port_i(port),
      .wdata_i  (cpu_wdata),
      .rd_port_i(port),
      .busy_i   (busy),
      .vld_o    (sel_vld),
      .bank_o   (sel_bank),
      .idx_o    (sel_idx),
      .rd_word_o(sel_word)
   );

   flagwt_issue #(
      .NUM_PORTS(NUM_PORTS),
      .PORT_W   (PORT_W),
      .BANK_W   (BANK_W),
      .IDX_W    (IDX_W)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .dp_wr_i   (dp_wr),
      .dp_port_i (port),
      .wbit_i    (cpu_wdata[0]),
      .sel_vld_i (sel_vld),
      .sel_bank_i(sel_bank),
      .sel_idx_i (sel_idx),
      .rq_ready_i(rq_ready),
      .rq_done_i (rq_done),
      .busy_o    (busy),
      .rq_valid_o(rq_valid),
      .rq_bank_o (rq_bank),
      .rq_index_o(rq_index),
      .rq_value_o(rq_value)
   );

   always_comb begin
      cpu_rdata = '0;
      if (cpu_rd) begin
         case (hit)
            HIT_SEL:  cpu_rdata = sel_word;
            HIT_BUSY: cpu_rdata[0] = busy;
            default:  cpu_rdata = '0;
         endcase
      end
   end

   // R4: an invalid selector never produces a request
   a_r4_invalid_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_wr && !busy && !sel_vld[port]) |=> !rq_valid);

   // R9: reads outside the mapped registers return zero
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && (hit == HIT_NONE || hit == HIT_DPORT)) |-> (cpu_rdata == '0));

endmodule

// File: tb/flagwt_ctrl_bench.sv
module flagwt_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] SEL_MASK = 64'h8000_0000_0000_007F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [7:0]  cpu_space = '0;
   logic [7:0]  cpu_off = '0;
   logic [63:0] cpu_wdata = '0;
   logic [63:0] cpu_rdata;
   logic        rq_valid;
   logic        rq_ready = 1'b0;
   logic [0:0]  rq_bank;
   logic [5:0]  rq_index;
   logic        rq_value;
   logic        rq_done = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [63:0] sel_exp [2];

   always #(CLK_PERIOD / 2) clk = ~clk;

   flagwt_ctrl u_flagwt_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_wr   (cpu_wr),
      .cpu_rd   (cpu_rd),
      .cpu_space(cpu_space),
      .cpu_off  (cpu_off),
      .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata),
      .rq_valid (rq_valid),
      .rq_ready (rq_ready),
      .rq_bank  (rq_bank),
      .rq_index (rq_index),
      .rq_value (rq_value),
      .rq_done  (rq_done)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] sp, input logic [7:0] off,
                            input logic [63:0] d);
      cpu_wr    = 1'b1;
      cpu_space = sp;
      cpu_off   = off;
      cpu_wdata = d;
      @(negedge clk);
      cpu_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] sp, input logic [7:0] off,
                           output logic [63:0] d);
      cpu_rd    = 1'b1;
      cpu_space = sp;
      cpu_off   = off;
      #1;
      d = cpu_rdata;
      cpu_rd = 1'b0;
   endtask

   function automatic logic [63:0] req_word(input logic v, input logic b,
                                            input logic [5:0] i, input logic val);
      return {55'd0, v, b, i, val};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] rd;
      logic [63:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      bus_read(8'h6F, 8'h80, rd); chk(rd == 0, "R1 sel0", rd, 0);
      bus_read(8'h6F, 8'h88, rd); chk(rd == 0, "R1 sel1", rd, 0);
      bus_read(8'h6F, 8'hC0, rd); chk(rd == 0, "R1 busy", rd, 0);
      chk(rq_valid == 0, "R1 rq_valid", 64'(rq_valid), 0);

      // R2: selector field capture and readback
      bus_write(8'h6F, 8'h80, 64'hFFFF_FFFF_FFFF_FFFF);
      bus_read(8'h6F, 8'h80, rd);
      chk(rd == SEL_MASK, "R2 sel0 ones", rd, SEL_MASK);
      bus_write(8'h6F, 8'h88, 64'h0123_4567_89AB_CD2A);
      bus_read(8'h6F, 8'h88, rd);
      chk(rd == 64'h2A, "R2 sel1", rd, 64'h2A);
      sel_exp[1] = 64'h2A;

      // R4: invalid selectors drop data writes
      bus_write(8'h6F, 8'h80, 64'h0000_0000_0000_0045);
      bus_write(8'h6F, 8'h00, 64'h1);
      chk(rq_valid == 0, "R4 port0", 64'(rq_valid), 0);
      bus_write(8'h6F, 8'h08, 64'h1);
      chk(rq_valid == 0, "R4 port1", 64'(rq_valid), 0);
      bus_read(8'h6F, 8'hC0, rd); chk(rd == 0, "R4 busy", rd, 0);

      // R9: unmapped offsets, data-port reads, foreign space
      bus_write(8'h6F, 8'h80, 64'h8000_0000_0000_0011);
      sel_exp[0] = 64'h8000_0000_0000_0011;
      bus_read(8'h6F, 8'h90, rd); chk(rd == 0, "R9 off 0x90", rd, 0);
      bus_read(8'h6F, 8'h00, rd); chk(rd == 0, "R9 dport read", rd, 0);
      bus_read(8'h6E, 8'h80, rd); chk(rd == 0, "R9 other space", rd, 0);
      bus_write(8'h6E, 8'h80, 64'h8000_0000_0000_007F);
      bus_write(8'h6E, 8'h00, 64'h1);
      chk(rq_valid == 0, "R9 foreign dport write", 64'(rq_valid), 0);
      bus_write(8'h6F, 8'h40, 64'hFFFF_FFFF_FFFF_FFFF);
      bus_read(8'h6F, 8'h80, rd);
      chk(rd == sel_exp[0], "R9 sel0 untouched", rd, sel_exp[0]);

      // R8: busy register ignores writes
      bus_write(8'h6F, 8'hC0, 64'hFFFF_FFFF_FFFF_FFFF);
      bus_read(8'h6F, 8'hC0, rd); chk(rd == 0, "R8 write ignored", rd, 0);
      chk(rq_valid == 0, "R8 no request", 64'(rq_valid), 0);

      // Sweep: both ports, both banks, every index
      for (int p = 0; p < 2; p++) begin
         for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 64; i++) begin
               logic [63:0] sv;
               logic [63:0] dw;
               logic [63:0] exp_rq;
               int q;
               q  = 1 - p;
               sv = 64'h8000_0F00_0000_0300 | (64'(b) << 6) | 64'(i);
               bus_write(8'h6F, 8'(8'h80 + 8 * p), sv);
               sel_exp[p] = sv & SEL_MASK;
               dw = 64'(i * 37 + p * 11 + b * 5) ^ 64'hDEAD_0000_0000_0000;
               bus_write(8'h6F, 8'(8 * p), dw);
               exp_rq = req_word(1'b1, 1'(b), 6'(i), dw[0]);
               held = req_word(rq_valid, rq_bank, rq_index, rq_value);
               chk(held == exp_rq, "R3 request fields", held, exp_rq);
               bus_read(8'h6F, 8'hC0, rd);
               chk(rd == 64'h1, "R8 busy bit set", rd, 64'h1);

               if (i % 6 == 1) begin
                  rq_done = 1'b1;
                  @(negedge clk);
                  rq_done = 1'b0;
                  bus_read(8'h6F, 8'hC0, rd);
                  chk(rd == 64'h1, "R6 early done ignored", rd, 64'h1);
               end

               if (i % 4 == 0) begin
                  bus_write(8'h6F, 8'(8'h80 + 8 * q), 64'h8000_0000_0000_0055);
                  bus_write(8'h6F, 8'(8'h80 + 8 * p), 64'h0);
                  bus_write(8'h6F, 8'(8 * p), ~dw);
                  bus_write(8'h6F, 8'(8 * q), dw);
                  held = req_word(rq_valid, rq_bank, rq_index, rq_value);
                  chk(held == exp_rq, "R7 pending request unchanged", held, exp_rq);
                  bus_read(8'h6F, 8'(8'h80 + 8 * q), rd);
                  chk(rd == sel_exp[q], "R7 other selector frozen", rd, sel_exp[q]);
                  bus_read(8'h6F, 8'(8'h80 + 8 * p), rd);
                  chk(rd == sel_exp[p], "R7 own selector frozen", rd, sel_exp[p]);
               end

               for (int w = 0; w < i % 3; w++) begin
                  @(negedge clk);
                  held = req_word(rq_valid, rq_bank, rq_index, rq_value);
                  chk(held == exp_rq, "R5 hold while not ready", held, exp_rq);
               end

               rq_ready = 1'b1;
               @(negedge clk);
               rq_ready = 1'b0;
               chk(rq_valid == 0, "R5 drop after ready", 64'(rq_valid), 0);
               bus_read(8'h6F, 8'hC0, rd);
               chk(rd == 64'h1, "R6 busy until done", rd, 64'h1);

               if (i % 5 == 0) begin
                  repeat (2) @(negedge clk);
                  bus_read(8'h6F, 8'hC0, rd);
                  chk(rd == 64'h1, "R6 busy waits", rd, 64'h1);
               end

               rq_done = 1'b1;
               @(negedge clk);
               rq_done = 1'b0;
               bus_read(8'h6F, 8'hC0, rd);
               chk(rd == 0, "R6 busy cleared", rd, 0);
               chk(rq_valid == 0, "R7 no reissue", 64'(rq_valid), 0);
               bus_read(8'h6F, 8'(8'h80 + 8 * p), rd);
               chk(rd == sel_exp[p], "R2 sweep readback", rd, sel_exp[p]);
            end
         end
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule